// File: doc/BRIEF.md
# Two-Wire Quad 8-Bit Converter Register Interface

This block is a write-only two-wire serial target that feeds a bank of four 8-bit converter channels. Every channel has two registers. A pending register takes new codes as they arrive. A live register drives the converter and appears on the `chan_code` port. Bytes arrive on SCL/SDA, which are oversampled by the system clock. A command byte picks a channel or asks for a bank clear. The byte after it carries the code. Pending values become live together, and only when a STOP closes a transaction that addressed this device.

The receiver is one state machine with these states. S_IDLE waits for a START. S_ADDR shifts in the address byte. S_CMD shifts in a command byte. S_DATA shifts in the code for the selected channel. S_DUMMY shifts in the byte that follows a clear command and discards it. S_ACK pulls SDA low for the ninth bit. S_IGNORE waits out a transaction meant for another device.

The transitions are as follows. A START leads from any state to S_ADDR, and a STOP leads from any state to S_IDLE. A matching address leads S_ADDR to S_ACK and then to S_CMD. Any other address leads to S_IGNORE. A command byte leads through S_ACK to S_DATA, or to S_DUMMY when its clear bit is set. A data byte or a dummy byte leads through S_ACK back to S_CMD. SDA is modelled as open drain, so the block drives only an output enable.

Top module: `quad_dac_i2c_if`

## Requirements
- R1: A synchronous reset clears all pending and live registers to zero, releases `sda_oe`, clears `pd_cmd`, and returns the receiver to S_IDLE.
- R2: The address byte `0101_0` + `pin_addr[1]` + `pin_addr[0]` + `0` is acknowledged, where the last bit 0 means write. Any other address byte is left unacknowledged, including a read request. The bytes that follow it are also left unacknowledged and have no effect, until the next START.
- R3: `chan_code` changes only after a STOP. That STOP must close a transaction that was addressed to this device and that carried at least one command byte. Bytes received earlier in the transaction leave `chan_code` unchanged.
- R4: A command byte with bit 4 clear selects channel `cmd[1:0]`. The next byte is written to that channel's pending register and replaces any earlier value.
- R5: A command byte with bit 4 set clears all pending registers. The following qualifying STOP drives every channel to zero, except the channels that later pairs in the same transaction rewrote.
- R6: After a clear command, the next byte is acknowledged and then discarded. The command/data pairs after it are handled normally.
- R7: Each accepted byte is acknowledged. `sda_oe` rises after the SCL fall that ends the eighth bit and falls after the SCL fall that ends the ninth bit, so it changes only while SCL is low.
- R8: A repeated START ends the transaction without changing `chan_code`. Pending values are kept.
- R9: A STOP that closes a transaction addressed to another device changes nothing.
- R10: Pending values are made live by a later addressed transaction that carries at least one command byte and ends in STOP. A transaction that carries only the address byte commits nothing.
- R11: Command bits 7:5 and bit 2 have no effect. Bit 3 of each command byte appears on `pd_cmd` and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level, as seen on the wired bus |
| pin_addr | input | 2 | Strapped low address bits |
| sda_oe | output | 1 | Pull SDA low while high (acknowledge) |
| pd_cmd | output | 1 | Bit 3 of the last command byte received |
| chan_code | output | 4x8 | Live code of each channel, channel n at bits [8n+7:8n] |

## Verification
The assertions assume that SCL stays in each level for several system clocks. That keeps the synchronised SCL from switching in the cycle after a detected edge, and it keeps a START and a STOP out of the same cycle. They also assume that SDA moves only while SCL is low, except at START and STOP. The bench holds SCL in each level for at least four system clocks and changes its SDA drive only in the low phase. At START and STOP it raises SCL before it moves SDA. Random transactions mix foreign addresses, clear commands, and endings by STOP or by repeated START, all within these rules.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_DATA,
        S_DUMMY,
        S_ACK,
        S_IGNORE
    } rx_state_t;

    // upper five address bits: fixed prefix plus strap bit tied low for four channels
    localparam logic [4:0] ADDR_HIGH   = 5'b01010;
    localparam int         CMD_CLR_BIT = 4;
    localparam int         CMD_PD_BIT  = 3;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    always_comb begin
        scl_hi    = scl_pipe[SYNC_STAGES-1];
        sda_bit   = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_hi & ~scl_q;
        scl_fall  = ~scl_hi & scl_q;
        start_det = scl_hi & scl_q & sda_q & ~sda_bit;
        stop_det  = scl_hi & scl_q & ~sda_q & sda_bit;
    end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_if_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_bit,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [1:0]       pin_addr,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic [DW-1:0]    wr_data,
    output logic             clr_all,
    output logic             commit,
    output logic             pd_cmd,
    output rx_state_t        state
);
    localparam int BCW = $clog2(DW);

    rx_state_t        st, st_n, after, after_n;
    logic [DW-2:0]    shreg;
    logic [BCW-1:0]   bitcnt;
    logic             ack_on, addressed, cmd_seen, pd_q;
    logic [SEL_W-1:0] sel_q;
    logic [DW-1:0]    byte_now;
    logic             receiving, byte_done, addr_hit;

    always_comb begin
        byte_now  = {shreg, sda_bit};
        receiving = (st == S_ADDR) || (st == S_CMD) || (st == S_DATA) || (st == S_DUMMY);
        byte_done = receiving && scl_rise && (bitcnt == BCW'(DW - 1));
        addr_hit  = (byte_now == {ADDR_HIGH, pin_addr, 1'b0});
    end

    // next state and pulse outputs
    always_comb begin
        st_n    = st;
        after_n = after;
        wr_en   = 1'b0;
        clr_all = 1'b0;
        if (start_det) begin
            st_n = S_ADDR;
        end else if (stop_det) begin
            st_n = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE, S_IGNORE: ;
                S_ADDR: if (byte_done) begin
                    st_n    = addr_hit ? S_ACK : S_IGNORE;
                    after_n = S_CMD;
                end
                S_CMD: if (byte_done) begin
                    st_n    = S_ACK;
                    after_n = byte_now[CMD_CLR_BIT] ? S_DUMMY : S_DATA;
                    clr_all = byte_now[CMD_CLR_BIT];
                end
                S_DATA: if (byte_done) begin
                    st_n    = S_ACK;
                    after_n = S_CMD;
                    wr_en   = 1'b1;
                end
                S_DUMMY: if (byte_done) begin
                    st_n    = S_ACK;
                    after_n = S_CMD;
                end
                S_ACK: if (scl_fall && ack_on) st_n = after;
                default: st_n = S_IDLE;
            endcase
        end
        commit  = stop_det && addressed && cmd_seen;
        wr_data = byte_now;
        wr_sel  = sel_q;
        sda_oe  = ack_on;
        pd_cmd  = pd_q;
        state   = st;
    end

    // state register and byte datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            after     <= S_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            ack_on    <= 1'b0;
            addressed <= 1'b0;
            cmd_seen  <= 1'b0;
            sel_q     <= '0;
            pd_q      <= 1'b0;
        end else begin
            st    <= st_n;
            after <= after_n;
            if (start_det || stop_det) begin
                bitcnt    <= '0;
                ack_on    <= 1'b0;
                addressed <= 1'b0;
                cmd_seen  <= 1'b0;
            end else begin
                if (receiving && scl_rise) begin
                    shreg  <= byte_now[DW-2:0];
                    bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
                end
                if (st == S_ADDR && byte_done && addr_hit) addressed <= 1'b1;
                if (st == S_CMD && byte_done) begin
                    cmd_seen <= 1'b1;
                    sel_q    <= byte_now[SEL_W-1:0];
                    pd_q     <= byte_now[CMD_PD_BIT];
                end
                if (st == S_ACK && scl_fall) ack_on <= ~ack_on;
            end
        end
    end
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank #(
    parameter int NCH   = 4,
    parameter int DW    = 8,
    parameter int SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     clr_all,
    input  logic                     commit,
    output logic [NCH-1:0][DW-1:0]   live
);
    logic [NCH-1:0][DW-1:0] pend;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= '0;
                live[g] <= '0;
            end else begin
                if (clr_all)
                    pend[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    pend[g] <= wr_data;
                if (commit) live[g] <= pend[g];
            end
        end
    end
endmodule

// File: rtl/quad_dac_i2c_if.sv
module quad_dac_i2c_if
    import dac_if_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [1:0]             pin_addr,
    output logic                   sda_oe,
    output logic                   pd_cmd,
    output logic [NCH-1:0][DW-1:0] chan_code
);
    localparam int SEL_W = $clog2(NCH);

    logic             scl_hi, scl_rise, scl_fall, sda_bit, start_det, stop_det;
    logic             wr_en, clr_all, commit;
    logic [SEL_W-1:0] wr_sel;
    logic [DW-1:0]    wr_data;
    rx_state_t        rx_state;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_bit(sda_bit), .start_det(start_det), .stop_det(stop_det)
    );

    dac_cmd_rx #(.DW(DW), .SEL_W(SEL_W)) u_rx (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_bit(sda_bit), .start_det(start_det), .stop_det(stop_det),
        .pin_addr(pin_addr), .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .clr_all(clr_all), .commit(commit),
        .pd_cmd(pd_cmd), .state(rx_state)
    );

    dac_latch_bank #(.NCH(NCH), .DW(DW), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clr_all(clr_all), .commit(commit), .live(chan_code)
    );
endmodule

// File: rtl/quad_dac_i2c_if_checker.sv
module quad_dac_i2c_if_checker
    import dac_if_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_hi,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   sda_oe,
    input rx_state_t              rx_state,
    input logic [NCH-1:0][DW-1:0] chan_code
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_code == '0 && !sda_oe && rx_state == S_IDLE)); // R1

    AST_LIVE_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        !stop_det |=> $stable(chan_code)); // R3

    AST_REPSTART_HOLDS: assert property (@(posedge clk) disable iff (rst)
        start_det |=> $stable(chan_code)); // R8

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sda_oe)) |-> !scl_hi); // R7

    AST_ACK_IN_ACK_STATE: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> rx_state == S_ACK); // R7

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
        rx_state == S_IGNORE |-> !sda_oe); // R2
endmodule

bind quad_dac_i2c_if quad_dac_i2c_if_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .scl_hi(scl_hi), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .rx_state(rx_state),
    .chan_code(chan_code)
);

// File: tb/quad_dac_i2c_if_bench.sv
`timescale 1ns/1ps
module quad_dac_i2c_if_bench;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int Q   = 4;
    localparam logic [7:0] DEV = 8'h54;   // 0101_0 + pins 10 + write
    localparam int PH_IDLE = 0, PH_ADDR = 1, PH_CMD = 2, PH_DATA = 3, PH_DUMMY = 4, PH_IGN = 5;

    logic clk = 1'b0, rst = 1'b1, scl_drv = 1'b1, sda_drv = 1'b1;
    logic [1:0] pin_addr = 2'b10;
    logic sda_oe, pd_cmd, sda_line;
    logic [NCH-1:0][DW-1:0] chan_code;

    assign sda_line = sda_drv & ~sda_oe;
    always #2.5 clk = ~clk;

    quad_dac_i2c_if u_quad_dac_i2c_if (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line),
        .pin_addr(pin_addr), .sda_oe(sda_oe), .pd_cmd(pd_cmd), .chan_code(chan_code)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic [DW-1:0] m_in [NCH];
    logic [DW-1:0] m_out[NCH];
    int ph = PH_IDLE, m_sel = 0;
    bit m_adr = 0, m_cmd = 0, m_pd = 0;

    function automatic bit exp_ack(int phase, logic [7:0] b);
        if (phase == PH_ADDR) return b == DEV;
        return (phase == PH_CMD || phase == PH_DATA || phase == PH_DUMMY);
    endfunction

    function automatic int next_phase(int phase, logic [7:0] b);
        case (phase)
            PH_ADDR:  return (b == DEV) ? PH_CMD : PH_IGN;
            PH_CMD:   return b[4] ? PH_DUMMY : PH_DATA;
            PH_DATA:  return PH_CMD;
            PH_DUMMY: return PH_CMD;
            default:  return phase;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic check_outs(string tag);
        for (int c = 0; c < NCH; c++)
            chk(chan_code[c] == m_out[c], tag, chan_code[c], m_out[c]);
        chk(pd_cmd == m_pd, {tag, " R11 pd"}, pd_cmd, m_pd);
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; wq(1);
        scl_drv = 1'b1; wq(1);
        sda_drv = 1'b0; wq(1);
        scl_drv = 1'b0; wq(1);
        ph = PH_ADDR; m_adr = 0; m_cmd = 0;
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; wq(1);
        scl_drv = 1'b1; wq(1);
        sda_drv = 1'b1; wq(4);
        if (m_adr && m_cmd)
            for (int c = 0; c < NCH; c++) m_out[c] = m_in[c];
        ph = PH_IDLE; m_adr = 0; m_cmd = 0;
    endtask

    task automatic tx_byte(logic [7:0] b);
        bit ea;
        ea = exp_ack(ph, b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(1);
            scl_drv = 1'b1; wq(2);
            scl_drv = 1'b0; wq(1);
        end
        sda_drv = 1'b1; wq(1);
        scl_drv = 1'b1; wq(1);
        chk(sda_oe == ea, "R7 R2 ack on ninth pulse", sda_oe, ea);
        wq(1);
        scl_drv = 1'b0; wq(1);
        chk(sda_oe == 1'b0, "R7 ack released", sda_oe, 0);
        case (ph)
            PH_ADDR: m_adr = (b == DEV);
            PH_CMD: begin
                m_cmd = 1; m_pd = b[3];
                if (b[4]) for (int c = 0; c < NCH; c++) m_in[c] = '0;
                else m_sel = int'(b[1:0]);
            end
            PH_DATA: m_in[m_sel] = b;
            default: ;
        endcase
        ph = next_phase(ph, b);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, cmd;
        void'($urandom(32'd7331));
        for (int c = 0; c < NCH; c++) begin m_in[c] = '0; m_out[c] = '0; end
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_outs("R1 reset state");
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

        // R4 pairs, R3 nothing live before STOP
        i2c_start(); tx_byte(DEV);
        tx_byte(8'h01); tx_byte(8'hA5);
        tx_byte(8'h03); tx_byte(8'h3C);
        check_outs("R3 unchanged mid transaction");
        i2c_stop();
        check_outs("R4 R3 pair write committed");

        // R4 overwrite, R11 reserved and bit 2 ignored, pd
        i2c_start(); tx_byte(DEV);
        tx_byte(8'h01); tx_byte(8'h11);
        tx_byte(8'h01); tx_byte(8'h22);
        tx_byte(8'h06); tx_byte(8'h77);
        tx_byte(8'hE8); tx_byte(8'h5A);
        i2c_stop();
        check_outs("R4 R11 overwrite and ignored bits");

        // R5 R6 clear, dummy, then a pair
        i2c_start(); tx_byte(DEV);
        tx_byte(8'h10); tx_byte(8'hFF);
        tx_byte(8'h02); tx_byte(8'h99);
        check_outs("R5 outputs hold before STOP");
        i2c_stop();
        check_outs("R5 R6 clear then pair");

        // R8 repeated start, R9 foreign STOP
        i2c_start(); tx_byte(DEV);
        tx_byte(8'h00); tx_byte(8'h44);
        i2c_start(); tx_byte(8'h56);
        tx_byte(8'h00);
        check_outs("R8 repeated start keeps outputs");
        i2c_stop();
        check_outs("R9 foreign STOP commits nothing");

        // R10 address only then command + STOP
        i2c_start(); tx_byte(DEV); i2c_stop();
        check_outs("R10 address only commits nothing");
        i2c_start(); tx_byte(DEV); tx_byte(8'h01); i2c_stop();
        check_outs("R10 pending committed later");

        // R2 read request not accepted
        i2c_start(); tx_byte(8'h55);
        tx_byte(8'h00); tx_byte(8'hEE);
        i2c_stop();
        check_outs("R2 read request ignored");

        // random traffic
        for (int t = 0; t < 40; t++) begin
            a = ($urandom % 5 == 0) ? 8'($urandom) : DEV;
            i2c_start(); tx_byte(a);
            for (int i = 0; i < int'($urandom % 4); i++) begin
                cmd = 8'($urandom);
                if ($urandom % 8 != 0) cmd[4] = 1'b0;
                tx_byte(cmd);
                tx_byte(8'($urandom));
            end
            if ($urandom % 4 != 0) i2c_stop();
            check_outs("R3 R5 R8 random transaction");
        end
        i2c_stop();
        check_outs("R10 final STOP");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule